// File: doc/BRIEF.md
# Execute-Stage Operand Bypass and Load-Use Interlock

This block sits beside the execute stage of a five-stage in-order integer pipeline. Each cycle it compares the two source register indices of the instruction held in the decode/execute pipeline register with the destination indices of the two older instructions: the one in the execute/memory register and the one in the memory/writeback register. For each operand it produces a two-bit source select and the operand value already muxed from the chosen source. The choices are the register-file read data, the ALU result of the execute/memory producer, or the writeback value of the memory/writeback producer.

A load sitting in the execute/memory register has no data yet, so it is never used as a bypass source. When such a load writes a register that the younger instruction reads, the block raises a stall request and a bubble request for exactly one cycle. After that cycle the load has moved to writeback and the value can be bypassed from there. For a store, the second source feeds the store-data path rather than the second ALU operand, because the second ALU operand of a store is its immediate. The two paths therefore have separate select outputs.

Top module: `fwd_unit`

## Requirements
- R1: With no matching producer, every select output is 2'b00 (register file) and `op_a`, `op_b` and `st_data` equal `rf_rs1_data`, `rf_rs2_data` and `rf_rs2_data`. After reset, `stall` and `bubble` are low.
- R2: A producer whose destination index is 0, or whose write enable is low, never causes a bypass and never causes a stall.
- R3: When the execute/memory producer is not a load (opcode other than 7'h03), is enabled and its destination equals a source index, that operand's select is 2'b10 and its value is `exm_alu_result`.
- R4: When the memory/writeback producer is enabled and its nonzero destination equals a source index, and the execute/memory stage does not bypass that operand, the select is 2'b01 and the value is `mwb_wdata`.
- R5: When both producers match the same source, the execute/memory producer wins (select 2'b10).
- R6: A load (opcode 7'h03) in the execute/memory stage never drives a select of 2'b10. The operand falls back to the memory/writeback match or to the register file.
- R7: A load in the execute/memory stage that is enabled, has a nonzero destination, and whose destination equals `id_rs1` or `id_rs2` raises `stall` and `bubble` together in the same cycle. Both are combinational from the inputs.
- R8: `stall` is never high on two consecutive cycles. If the load-use condition is still present in the cycle after a stall, the outputs are low in that cycle.
- R9: When `id_opcode` is 7'h23 (store), `sel_b` is 2'b00 and `op_b` equals `rf_rs2_data`, while `sel_st` and `st_data` carry the bypass decision for rs2. For any other opcode, `sel_st` is 2'b00 and `st_data` equals `rf_rs2_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_rs1 | input | REG_AW | First source index of the consumer |
| id_rs2 | input | REG_AW | Second source index of the consumer |
| id_opcode | input | 7 | Opcode of the consumer |
| exm_rd | input | REG_AW | Destination index in the execute/memory stage |
| exm_we | input | 1 | Register write enable in the execute/memory stage |
| exm_opcode | input | 7 | Opcode of the execute/memory producer |
| exm_alu_result | input | XLEN | ALU result held in the execute/memory stage |
| mwb_rd | input | REG_AW | Destination index in the memory/writeback stage |
| mwb_we | input | 1 | Register write enable in the memory/writeback stage |
| mwb_wdata | input | XLEN | Writeback value in the memory/writeback stage |
| rf_rs1_data | input | XLEN | Register-file read of rs1 |
| rf_rs2_data | input | XLEN | Register-file read of rs2 |
| sel_a | output | 2 | Source select for ALU operand A |
| sel_b | output | 2 | Source select for ALU operand B |
| sel_st | output | 2 | Source select for store data |
| op_a | output | XLEN | Bypassed ALU operand A |
| op_b | output | XLEN | Bypassed ALU operand B |
| st_data | output | XLEN | Bypassed store data |
| stall | output | 1 | Hold fetch and decode for one cycle |
| bubble | output | 1 | Insert a no-op behind the consumer |

## Verification
Almost all of the logic is combinational, so a wrong compare or priority shows up on the select and value outputs in the same cycle as the input pattern that exposes it. The bench checks each cycle's vector before the next edge. The only stored state is the one-cycle stall guard. A guard stuck high would hide the first stall. A guard stuck low would let `stall` stay high on the cycle after a load-use stall. Either fault becomes visible one edge after a load-use pattern, and the bench holds that pattern across two back-to-back cycles to expose it.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  localparam int OPC_W = 7;

  localparam logic [OPC_W-1:0] OPC_LOAD  = 7'h03;
  localparam logic [OPC_W-1:0] OPC_STORE = 7'h23;

  // Operand source select codes; other stages decode these bit patterns.
  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_MWB = 2'b01,
    SRC_EXM = 2'b10
  } fwd_src_e;

endpackage

// File: rtl/fwd_pick.sv
module fwd_pick
  import fwd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_idx,
  input  logic [REG_AW-1:0] exm_rd,
  input  logic              exm_we,
  input  logic              exm_is_load,
  input  logic [REG_AW-1:0] mwb_rd,
  input  logic              mwb_we,
  output fwd_src_e          src
);

  logic src_live;
  logic hit_exm;
  logic hit_mwb;

  always_comb begin
    src_live = (src_idx != '0);
    hit_exm  = src_live && exm_we && !exm_is_load && (exm_rd == src_idx);
    hit_mwb  = src_live && mwb_we && (mwb_rd == src_idx);
    if (hit_exm) begin
      src = SRC_EXM;
    end else if (hit_mwb) begin
      src = SRC_MWB;
    end else begin
      src = SRC_RF;
    end
  end

endmodule

// File: rtl/fwd_mux.sv
module fwd_mux
  import fwd_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  fwd_src_e        sel,
  input  logic [XLEN-1:0] rf_val,
  input  logic [XLEN-1:0] exm_val,
  input  logic [XLEN-1:0] mwb_val,
  output logic [XLEN-1:0] out_val
);

  always_comb begin
    unique case (sel)
      SRC_EXM: out_val = exm_val;
      SRC_MWB: out_val = mwb_val;
      default: out_val = rf_val;
    endcase
  end

endmodule

// File: rtl/lu_detect.sv
module lu_detect
  import fwd_pkg::*;
#(
  parameter int REG_AW    = 5,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] id_rs1,
  input  logic [REG_AW-1:0] id_rs2,
  input  logic [REG_AW-1:0] exm_rd,
  input  logic              exm_we,
  input  logic              exm_is_load,
  output logic              stall,
  output logic              bubble
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [SYNC_DEPTH-1:0] rst_sync_q;
  logic                  rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_DEPTH-2:0], 1'b1};
    end
  end

  assign rst_ok = rst_sync_q[SYNC_DEPTH-1];

  logic hazard;
  logic guard_q;
  logic guard_d;
  logic guard_en;

  always_comb begin
    hazard   = exm_we && exm_is_load && (exm_rd != '0) &&
               ((exm_rd == id_rs1) || (exm_rd == id_rs2));
    stall    = hazard && !guard_q;
    bubble   = stall;
    guard_en = stall || guard_q;
    guard_d  = stall;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      guard_q <= 1'b0;
    end else if (guard_en) begin
      guard_q <= guard_d;
    end
  end

  assert_stall_oneshot_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    stall |=> !stall);

  assert_bubble_with_stall_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    bubble == stall);

  assert_no_stall_x0_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    (exm_rd == '0 || !exm_we) |-> !stall);

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] id_rs1,
  input  logic [REG_AW-1:0] id_rs2,
  input  logic [6:0]        id_opcode,
  input  logic [REG_AW-1:0] exm_rd,
  input  logic              exm_we,
  input  logic [6:0]        exm_opcode,
  input  logic [XLEN-1:0]   exm_alu_result,
  input  logic [REG_AW-1:0] mwb_rd,
  input  logic              mwb_we,
  input  logic [XLEN-1:0]   mwb_wdata,
  input  logic [XLEN-1:0]   rf_rs1_data,
  input  logic [XLEN-1:0]   rf_rs2_data,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic [1:0]        sel_st,
  output logic [XLEN-1:0]   op_a,
  output logic [XLEN-1:0]   op_b,
  output logic [XLEN-1:0]   st_data,
  output logic              stall,
  output logic              bubble
);

  localparam int NSRC = 2;

  logic exm_is_load;
  logic id_is_store;

  assign exm_is_load = (exm_opcode == OPC_LOAD);
  assign id_is_store = (id_opcode == OPC_STORE);

  logic [REG_AW-1:0] src_idx [NSRC];
  logic [XLEN-1:0]   rf_val  [NSRC];
  fwd_src_e          src_sel [NSRC];
  logic [XLEN-1:0]   fwd_val [NSRC];

  assign src_idx[0] = id_rs1;
  assign src_idx[1] = id_rs2;
  assign rf_val[0]  = rf_rs1_data;
  assign rf_val[1]  = rf_rs2_data;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    fwd_pick #(.REG_AW(REG_AW)) u_pick (
      .src_idx     (src_idx[g]),
      .exm_rd      (exm_rd),
      .exm_we      (exm_we),
      .exm_is_load (exm_is_load),
      .mwb_rd      (mwb_rd),
      .mwb_we      (mwb_we),
      .src         (src_sel[g])
    );

    fwd_mux #(.XLEN(XLEN)) u_mux (
      .sel     (src_sel[g]),
      .rf_val  (rf_val[g]),
      .exm_val (exm_alu_result),
      .mwb_val (mwb_wdata),
      .out_val (fwd_val[g])
    );
  end

  // Second source: ALU operand for most ops, store-data path for stores.
  always_comb begin
    sel_a = src_sel[0];
    op_a  = fwd_val[0];
    if (id_is_store) begin
      sel_b   = SRC_RF;
      op_b    = rf_rs2_data;
      sel_st  = src_sel[1];
      st_data = fwd_val[1];
    end else begin
      sel_b   = src_sel[1];
      op_b    = fwd_val[1];
      sel_st  = SRC_RF;
      st_data = rf_rs2_data;
    end
  end

  lu_detect #(.REG_AW(REG_AW)) u_lu (
    .clk         (clk),
    .rst_n       (rst_n),
    .id_rs1      (id_rs1),
    .id_rs2      (id_rs2),
    .exm_rd      (exm_rd),
    .exm_we      (exm_we),
    .exm_is_load (exm_is_load),
    .stall       (stall),
    .bubble      (bubble)
  );

  assert_sel_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a != 2'b11) && (sel_b != 2'b11) && (sel_st != 2'b11));

  assert_x0_not_bypassed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rs1 == '0) |-> (sel_a == SRC_RF));

  assert_load_not_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exm_is_load |-> (sel_a != SRC_EXM && sel_b != SRC_EXM && sel_st != SRC_EXM));

  assert_exm_priority_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (exm_we && !exm_is_load && exm_rd != '0 && exm_rd == id_rs1) |->
      (sel_a == SRC_EXM && op_a == exm_alu_result));

  assert_store_b_rf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    id_is_store |-> (sel_b == SRC_RF && op_b == rf_rs2_data));

  assert_nonstore_st_rf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !id_is_store |-> (sel_st == SRC_RF && st_data == rf_rs2_data));

endmodule

// File: tb/fwd_unit_test.sv
module fwd_unit_test;

  localparam int XLEN   = 32;
  localparam int REG_AW = 5;
  localparam logic [6:0] OP_LD = 7'h03;
  localparam logic [6:0] OP_ST = 7'h23;
  localparam logic [6:0] OP_AL = 7'h33;
  localparam logic [XLEN-1:0] V_RF1 = 32'h1111_1111;
  localparam logic [XLEN-1:0] V_RF2 = 32'h2222_2222;
  localparam logic [XLEN-1:0] V_EXM = 32'hAAAA_0001;
  localparam logic [XLEN-1:0] V_MWB = 32'hBBBB_0002;

  logic clk = 1'b0;
  logic rst_n;
  logic [REG_AW-1:0] id_rs1, id_rs2, exm_rd, mwb_rd;
  logic [6:0] id_opcode, exm_opcode;
  logic exm_we, mwb_we;
  logic [XLEN-1:0] exm_alu_result, mwb_wdata, rf_rs1_data, rf_rs2_data;
  logic [1:0] sel_a, sel_b, sel_st;
  logic [XLEN-1:0] op_a, op_b, st_data;
  logic stall, bubble;

  always #2 clk = ~clk;

  fwd_unit #(.XLEN(XLEN), .REG_AW(REG_AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .id_rs1(id_rs1), .id_rs2(id_rs2), .id_opcode(id_opcode),
    .exm_rd(exm_rd), .exm_we(exm_we), .exm_opcode(exm_opcode),
    .exm_alu_result(exm_alu_result),
    .mwb_rd(mwb_rd), .mwb_we(mwb_we), .mwb_wdata(mwb_wdata),
    .rf_rs1_data(rf_rs1_data), .rf_rs2_data(rf_rs2_data),
    .sel_a(sel_a), .sel_b(sel_b), .sel_st(sel_st),
    .op_a(op_a), .op_b(op_b), .st_data(st_data),
    .stall(stall), .bubble(bubble)
  );

  typedef struct packed {
    logic [1:0]      sa, sb, ss;
    logic [XLEN-1:0] va, vb, vs;
    logic            stl, bub;
  } exp_t;

  exp_t exp_q[$];
  string tag_q[$];
  int n_checks = 0;
  int n_fail = 0;
  logic prev_stall = 1'b0;

  function automatic logic [1:0] ref_pick(input logic [REG_AW-1:0] rs);
    if (rs != 0 && exm_we && exm_opcode != OP_LD && exm_rd == rs) return 2'b10;
    if (rs != 0 && mwb_we && mwb_rd == rs) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [XLEN-1:0] ref_val(input logic [1:0] s, input logic [XLEN-1:0] rf);
    if (s == 2'b10) return V_EXM;
    if (s == 2'b01) return V_MWB;
    return rf;
  endfunction

  task automatic apply(input logic [REG_AW-1:0] rs1, input logic [REG_AW-1:0] rs2,
                       input logic [6:0] idop,
                       input logic [REG_AW-1:0] xrd, input logic xwe, input logic [6:0] xop,
                       input logic [REG_AW-1:0] wrd, input logic wwe, input string tag);
    exp_t e;
    logic [1:0] p1, p2;
    logic lu;
    @(posedge clk);
    #1;
    id_rs1 = rs1; id_rs2 = rs2; id_opcode = idop;
    exm_rd = xrd; exm_we = xwe; exm_opcode = xop;
    mwb_rd = wrd; mwb_we = wwe;
    p1 = ref_pick(rs1);
    p2 = ref_pick(rs2);
    e.sa = p1; e.va = ref_val(p1, V_RF1);
    if (idop == OP_ST) begin
      e.sb = 2'b00; e.vb = V_RF2;
      e.ss = p2;    e.vs = ref_val(p2, V_RF2);
    end else begin
      e.sb = p2;    e.vb = ref_val(p2, V_RF2);
      e.ss = 2'b00; e.vs = V_RF2;
    end
    lu = xwe && xop == OP_LD && xrd != 0 && (xrd == rs1 || xrd == rs2);
    e.stl = lu && !prev_stall;
    e.bub = e.stl;
    prev_stall = e.stl;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // Monitor: compares mid-cycle, away from the active edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_checks++;
      if (sel_a !== e.sa || sel_b !== e.sb || sel_st !== e.ss ||
          op_a !== e.va || op_b !== e.vb || st_data !== e.vs ||
          stall !== e.stl || bubble !== e.bub) begin
        n_fail++;
        $display("FAIL %s: got sa=%b sb=%b ss=%b a=%h b=%h s=%h stl=%b bub=%b exp sa=%b sb=%b ss=%b a=%h b=%h s=%h stl=%b bub=%b",
                 t, sel_a, sel_b, sel_st, op_a, op_b, st_data, stall, bubble,
                 e.sa, e.sb, e.ss, e.va, e.vb, e.vs, e.stl, e.bub);
      end
    end
  end

  initial begin
    int wd = 0;
    while (wd < 5000) begin
      @(posedge clk);
      wd++;
    end
    n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    id_rs1 = '0; id_rs2 = '0; id_opcode = OP_AL;
    exm_rd = '0; exm_we = 1'b0; exm_opcode = OP_AL;
    mwb_rd = '0; mwb_we = 1'b0;
    exm_alu_result = V_EXM; mwb_wdata = V_MWB;
    rf_rs1_data = V_RF1; rf_rs2_data = V_RF2;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: idle after reset, no producer match
    apply(5'd1, 5'd2, OP_AL, 5'd0, 1'b0, OP_AL, 5'd0, 1'b0, "R1 idle");
    apply(5'd1, 5'd2, OP_AL, 5'd7, 1'b1, OP_AL, 5'd8, 1'b1, "R1 no match");
    // R2: x0 and disabled writers
    apply(5'd0, 5'd0, OP_AL, 5'd0, 1'b1, OP_AL, 5'd0, 1'b1, "R2 x0");
    apply(5'd3, 5'd3, OP_AL, 5'd3, 1'b0, OP_AL, 5'd3, 1'b0, "R2 we low");
    apply(5'd0, 5'd4, OP_AL, 5'd0, 1'b1, OP_LD, 5'd9, 1'b1, "R2 load to x0 no stall");
    // R3 / R4
    apply(5'd6, 5'd2, OP_AL, 5'd6, 1'b1, OP_AL, 5'd0, 1'b0, "R3 exm rs1");
    apply(5'd1, 5'd6, OP_AL, 5'd6, 1'b1, OP_AL, 5'd0, 1'b0, "R3 exm rs2");
    apply(5'd1, 5'd9, OP_AL, 5'd0, 1'b0, OP_AL, 5'd9, 1'b1, "R4 mwb rs2");
    apply(5'd9, 5'd6, OP_AL, 5'd6, 1'b1, OP_AL, 5'd9, 1'b1, "R4 R3 split");
    // R5
    apply(5'd12, 5'd12, OP_AL, 5'd12, 1'b1, OP_AL, 5'd12, 1'b1, "R5 both match");
    // R6 / R7 / R8: load-use held two cycles
    apply(5'd12, 5'd3, OP_AL, 5'd12, 1'b1, OP_LD, 5'd12, 1'b1, "R6 R7 load-use stall");
    apply(5'd12, 5'd3, OP_AL, 5'd12, 1'b1, OP_LD, 5'd12, 1'b1, "R8 second cycle no stall");
    apply(5'd2, 5'd12, OP_AL, 5'd12, 1'b1, OP_LD, 5'd0, 1'b0, "R7 rs2 load-use stall");
    apply(5'd1, 5'd2, OP_AL, 5'd12, 1'b1, OP_LD, 5'd0, 1'b0, "R6 load no match");
    // R9: stores
    apply(5'd5, 5'd7, OP_ST, 5'd7, 1'b1, OP_AL, 5'd5, 1'b1, "R9 store exm data");
    apply(5'd5, 5'd7, OP_ST, 5'd0, 1'b0, OP_AL, 5'd7, 1'b1, "R9 store mwb data");
    apply(5'd5, 5'd7, OP_AL, 5'd7, 1'b1, OP_AL, 5'd0, 1'b0, "R9 non-store st_data");
    apply(5'd5, 5'd7, OP_ST, 5'd7, 1'b1, OP_LD, 5'd0, 1'b0, "R9 R7 store after load");
    apply(5'd1, 5'd2, OP_AL, 5'd0, 1'b0, OP_AL, 5'd0, 1'b0, "R1 final idle");

    repeat (3) @(posedge clk);
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: got %0d pending exp 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule